// File: doc/BRIEF.md
# Serial Status Port with Latched Interrupt

This block is the serial control port of a record/playback memory device. An external master selects it by pulling the select line low and then clocks in an eight-bit instruction, most significant bit first. After the instruction byte the port answers on its serial output. When the instruction is the read-interrupt opcode, the reply is the current interrupt status. For any other opcode the reply is zero. The SPI pins are oversampled by a fast system clock, so all logic lives in one clock domain.

The record/playback engine reports two events through single-cycle pulses: the end of the memory array was reached, or an end-of-message marker was found. A pulse only counts while an operation is running, and the end-of-message pulse only counts in playback mode, which includes message cueing. Either counted event latches a flag and asserts the open-drain interrupt. The interrupt stays asserted until the select line next falls. On that edge the flags are copied into a snapshot and then cleared, so a read-interrupt transfer returns the events that raised the interrupt. Pad cells outside the block turn the two enable outputs into a high-impedance MISO and an open-drain interrupt line.

Top module: `spiStatusPort`

## Requirements
- R1: `misoEn` is low while `ssN` is high and high while `ssN` is low, so the pad leaves MISO at high impedance whenever the device is not selected.
- R2: The instruction is captured from `mosi` on rising `sclk` edges, most significant bit first, and is decoded once the eighth bit has arrived.
- R3: `miso` changes only after a falling `sclk` edge, or when it is forced to 0 at a select edge. It holds its value at every other time.
- R4: `miso` is 0 for all eight bits of the instruction byte.
- R5: After the read-interrupt opcode 8'h30, the second byte is shifted out least significant bit first. Bit 0 is the overflow flag and bit 1 is the end-of-message flag, both as they stood at the falling edge of `ssN`. Bits 7 to 2 are 0.
- R6: After any opcode other than 8'h30, the second byte is all zeros.
- R7: A pulse on `ovfEvent` while `opActive` is high sets the overflow flag and asserts `intDrive`, in either playback or record mode.
- R8: A pulse on `eomEvent` counts only while `opActive` is high and `modePlay` is 1 (playback or cueing). In record mode (`modePlay` = 0) it leaves `intDrive` and the status unchanged.
- R9: Event pulses that arrive while `opActive` is low are ignored.
- R10: Once asserted, `intDrive` stays high until the next falling edge of `ssN`. It is then cleared together with both flags.
- R11: After reset `intDrive` is low and both flags read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rstN | input | 1 | Active-low asynchronous reset |
| ssN | input | 1 | Active-low slave select |
| sclk | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| misoEn | output | 1 | Output enable for the MISO pad (low means high impedance) |
| intDrive | output | 1 | Pull-down enable for the open-drain interrupt line (high pulls it low) |
| opActive | input | 1 | A record, playback or cueing operation is running |
| modePlay | input | 1 | 1 for playback or cueing, 0 for record |
| ovfEvent | input | 1 | Single-cycle pulse: end of memory reached |
| eomEvent | input | 1 | Single-cycle pulse: end-of-message marker found |

## Verification
The bench uses the default parameters: two synchronizer stages, an eight-bit instruction and read-interrupt opcode 8'h30. Each serial half period is eight system clocks, which leaves enough time for the synchronizer delay and the one-cycle decode before the first status bit must appear. With eight-bit bytes, the opcode 8'h31 differs from the read-interrupt opcode in a single bit, so one transfer tests that the decode compares every bit. Random runs mix the mode, the active flag and both event pulses, and compare each reply with a model of the flags.

// File: rtl/spiStatusPkg.sv
package spiStatusPkg;
  // Strobes from the control module to the datapath; at most one edge strobe per cycle
  typedef struct packed {
    logic startXfer;   // select just fell: snapshot flags, then clear them
    logic endXfer;     // select just rose
    logic sampleBit;   // rising serial clock while selected
    logic shiftOut;    // falling serial clock while selected
    logic loadStatus;  // read-interrupt opcode decoded
  } ctrlStrobe_t;
endpackage

// File: rtl/spiStatusCtrl.sv
module spiStatusCtrl
  import spiStatusPkg::*;
#(
  parameter int SYNC_STAGES = 2,          // must be at least 2
  parameter int CMD_W = 8,
  parameter logic [CMD_W-1:0] OPCODE = 8'h30
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ssN,
  input  logic             sclk,
  input  logic             mosi,
  input  logic [CMD_W-1:0] rxByte,
  output logic             mosiBit,
  output ctrlStrobe_t      strb
);
  localparam int CNT_W = $clog2(2 * CMD_W) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] LAST_CMD_BIT = CNT_W'(CMD_W - 1);

  logic [SYNC_STAGES-1:0] ssPipe, sclkPipe, mosiPipe;
  logic ssPrev, sclkPrev, ssS, sclkS;
  logic [CNT_W-1:0] bitCnt;
  logic decodePend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ssPipe   <= '1;
      sclkPipe <= '0;
      mosiPipe <= '0;
      ssPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      ssPipe   <= {ssPipe[SYNC_STAGES-2:0], ssN};
      sclkPipe <= {sclkPipe[SYNC_STAGES-2:0], sclk};
      mosiPipe <= {mosiPipe[SYNC_STAGES-2:0], mosi};
      ssPrev   <= ssS;
      sclkPrev <= sclkS;
    end
  end

  assign ssS     = ssPipe[SYNC_STAGES-1];
  assign sclkS   = sclkPipe[SYNC_STAGES-1];
  assign mosiBit = mosiPipe[SYNC_STAGES-1];

  always_comb begin
    strb.startXfer  = ssPrev & ~ssS;
    strb.endXfer    = ~ssPrev & ssS;
    strb.sampleBit  = ~ssS & ~sclkPrev & sclkS;
    strb.shiftOut   = ~ssS & sclkPrev & ~sclkS;
    strb.loadStatus = decodePend && (rxByte == OPCODE);
  end

  // Bit counter saturates so that later bytes never decode again
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt     <= '0;
      decodePend <= 1'b0;
    end else begin
      decodePend <= strb.sampleBit && (bitCnt == LAST_CMD_BIT);
      if (strb.startXfer)
        bitCnt <= '0;
      else if (strb.sampleBit && bitCnt != CNT_MAX)
        bitCnt <= bitCnt + 1'b1;
    end
  end
endmodule

// File: rtl/spiStatusData.sv
module spiStatusData
  import spiStatusPkg::*;
#(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strb,
  input  logic             mosiBit,
  input  logic             opActive,
  input  logic             modePlay,
  input  logic             ovfEvent,
  input  logic             eomEvent,
  output logic [CMD_W-1:0] rxByte,
  output logic             misoBit,
  output logic             ovfFlag,
  output logic             eomFlag
);
  localparam int PAD_W = CMD_W - 2;

  logic [CMD_W-1:0] snapshot, txShift;
  logic ovfHit, eomHit;

  assign ovfHit = ovfEvent & opActive;
  assign eomHit = eomEvent & opActive & modePlay;

  // Flags: a new event wins over the clear at the start of a transfer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag  <= 1'b0;
      eomFlag  <= 1'b0;
      snapshot <= '0;
    end else begin
      ovfFlag <= (ovfFlag & ~strb.startXfer) | ovfHit;
      eomFlag <= (eomFlag & ~strb.startXfer) | eomHit;
      if (strb.startXfer)
        snapshot <= {{PAD_W{1'b0}}, eomFlag, ovfFlag};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte  <= '0;
      txShift <= '0;
      misoBit <= 1'b0;
    end else if (strb.startXfer || strb.endXfer) begin
      rxByte  <= '0;
      txShift <= '0;
      misoBit <= 1'b0;
    end else begin
      if (strb.sampleBit)
        rxByte <= {rxByte[CMD_W-2:0], mosiBit};
      if (strb.loadStatus)
        txShift <= snapshot;
      else if (strb.shiftOut) begin
        txShift <= txShift >> 1;
        misoBit <= txShift[0];
      end
    end
  end
endmodule

// File: rtl/spiStatusPort.sv
module spiStatusPort
  import spiStatusPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CMD_W = 8,
  parameter logic [CMD_W-1:0] OPCODE = 8'h30
) (
  input  logic clk,
  input  logic rstN,
  input  logic ssN,
  input  logic sclk,
  input  logic mosi,
  output logic miso,
  output logic misoEn,
  output logic intDrive,
  input  logic opActive,
  input  logic modePlay,
  input  logic ovfEvent,
  input  logic eomEvent
);
  ctrlStrobe_t strb;
  logic [CMD_W-1:0] rxByte;
  logic mosiBit, ovfFlag, eomFlag;

  spiStatusCtrl #(.SYNC_STAGES(SYNC_STAGES), .CMD_W(CMD_W), .OPCODE(OPCODE)) uCtrl (
    .clk(clk), .rstN(rstN), .ssN(ssN), .sclk(sclk), .mosi(mosi),
    .rxByte(rxByte), .mosiBit(mosiBit), .strb(strb)
  );

  spiStatusData #(.CMD_W(CMD_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .mosiBit(mosiBit),
    .opActive(opActive), .modePlay(modePlay),
    .ovfEvent(ovfEvent), .eomEvent(eomEvent),
    .rxByte(rxByte), .misoBit(miso), .ovfFlag(ovfFlag), .eomFlag(eomFlag)
  );

  assign misoEn   = ~ssN;
  assign intDrive = ovfFlag | eomFlag;
endmodule

// File: rtl/spiStatusChk.sv
module spiStatusChk
  import spiStatusPkg::*;
(
  input logic        clk,
  input logic        rstN,
  input ctrlStrobe_t strb,
  input logic        miso,
  input logic        intDrive,
  input logic        eomFlag,
  input logic        opActive,
  input logic        modePlay,
  input logic        ovfEvent,
  input logic        eomEvent
);
  // R3
  misoHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.shiftOut || strb.startXfer || strb.endXfer) |=> $stable(miso));
  // R10
  intHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    intDrive && !strb.startXfer |=> intDrive);
  // R10
  intClear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.startXfer && !ovfEvent && !eomEvent |=> !intDrive);
  // R9
  idleQuiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !intDrive && !opActive |=> !intDrive);
  // R8
  eomPlayOnly_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eomFlag) |-> $past(modePlay && opActive));
endmodule

bind spiStatusPort spiStatusChk uChk (
  .clk(clk), .rstN(rstN), .strb(strb), .miso(miso), .intDrive(intDrive),
  .eomFlag(eomFlag), .opActive(opActive), .modePlay(modePlay),
  .ovfEvent(ovfEvent), .eomEvent(eomEvent)
);

// File: tb/test_spiStatusPort.sv
module test_spiStatusPort;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam logic [7:0] RINT = 8'h30;

  logic clk = 1'b0, rstN = 1'b0;
  logic ssN = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic opActive = 1'b0, modePlay = 1'b0, ovfEvent = 1'b0, eomEvent = 1'b0;
  logic miso, misoEn, intDrive;
  int checks = 0, errors = 0;
  logic mOvf = 1'b0, mEom = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spiStatusPort i_spiStatusPort (
    .clk(clk), .rstN(rstN), .ssN(ssN), .sclk(sclk), .mosi(mosi),
    .miso(miso), .misoEn(misoEn), .intDrive(intDrive),
    .opActive(opActive), .modePlay(modePlay),
    .ovfEvent(ovfEvent), .eomEvent(eomEvent)
  );

  function automatic logic [7:0] expReply(input logic [7:0] op, input logic o, input logic e);
    return (op == RINT) ? {6'b0, e, o} : 8'h00;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic act, input logic play, input logic o, input logic e);
    @(negedge clk);
    opActive = act; modePlay = play; ovfEvent = o; eomEvent = e;
    @(negedge clk);
    ovfEvent = 1'b0; eomEvent = 1'b0;
    mOvf = mOvf | (o & act);
    mEom = mEom | (e & act & play);
    waitClk(3);
  endtask

  // One transfer: instruction byte MSB first, then a reply byte sampled LSB first
  task automatic xfer(input logic [7:0] cmd, output logic [7:0] b0, output logic [7:0] b1);
    @(negedge clk);
    ssN = 1'b0;
    waitClk(HALF);
    check("R1 enable while selected", {7'b0, misoEn}, 8'h01);
    for (int i = 0; i < 16; i++) begin
      mosi = (i < 8) ? cmd[7 - i] : 1'b0;
      waitClk(HALF);
      if (i < 8) b0[i] = miso; else b1[i - 8] = miso;
      sclk = 1'b1;
      waitClk(HALF);
      sclk = 1'b0;
    end
    waitClk(HALF);
    ssN = 1'b1;
    waitClk(HALF);
    check("R1 enable idle", {7'b0, misoEn}, 8'h00);
  endtask

  // Runs a transfer and checks both bytes and the interrupt clear against the model
  task automatic runXfer(input logic [7:0] op, input string req);
    logic [7:0] b0, b1, exp;
    exp = expReply(op, mOvf, mEom);
    mOvf = 1'b0; mEom = 1'b0;
    xfer(op, b0, b1);
    check("R4 instruction byte zero", b0, 8'h00);
    check(req, b1, exp);
    check("R10 cleared by transfer", {7'b0, intDrive}, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    waitClk(4);
    rstN = 1'b1;
    waitClk(4);
    // R11 reset state
    check("R11 reset interrupt", {7'b0, intDrive}, 8'h00);
    check("R1 enable at reset", {7'b0, misoEn}, 8'h00);
    runXfer(RINT, "R11 R5 status after reset");

    // R8: end of message in record mode is ignored
    pulse(1'b1, 1'b0, 1'b0, 1'b1);
    check("R8 record eom ignored", {7'b0, intDrive}, 8'h00);
    runXfer(RINT, "R8 status after record eom");

    // R9: events with no operation running are ignored
    pulse(1'b0, 1'b1, 1'b1, 1'b1);
    check("R9 inactive ignored", {7'b0, intDrive}, 8'h00);

    // R7: overflow in record mode
    pulse(1'b1, 1'b0, 1'b1, 1'b0);
    check("R7 overflow in record", {7'b0, intDrive}, 8'h01);
    waitClk(100);
    check("R10 held while idle", {7'b0, intDrive}, 8'h01);
    runXfer(RINT, "R5 R7 overflow status");
    runXfer(RINT, "R10 status cleared");

    // R5: both flags in playback
    pulse(1'b1, 1'b1, 1'b0, 1'b1);
    check("R8 playback eom", {7'b0, intDrive}, 8'h01);
    pulse(1'b1, 1'b1, 1'b1, 1'b0);
    runXfer(RINT, "R5 both flags");

    // R6 and R2: opcode one bit away from read-interrupt
    pulse(1'b1, 1'b1, 1'b1, 1'b1);
    runXfer(8'h31, "R6 R2 near opcode zero reply");
    runXfer(8'h0C, "R6 R2 reversed-order opcode zero reply");

    // Random mix
    for (int n = 0; n < 30; n++) begin
      pulse(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      check("R7 R8 R9 random interrupt", {7'b0, intDrive}, {7'b0, mOvf | mEom});
      if ($urandom % 3 == 0) runXfer(8'($urandom), "R6 random opcode");
      else runXfer(RINT, "R5 random status");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule